// File: doc/BRIEF.md
# Polled Receive Byte FIFO

This block is a 512-byte first-in first-out buffer between a line-side byte writer and a system-side byte reader. Both data sides use a valid/ready handshake. On the write side, a byte moves when `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the buffer is full. A byte offered while `wr_ready` is low is discarded, and the block raises `wr_overflow` for one cycle. It does not wait for the writer to retry. On the read side, `rd_valid` is high whenever at least one byte is stored, and `rd_data` already shows the oldest byte. A byte leaves when `rd_valid` and `rd_ready` are both high. Raising `rd_ready` while the buffer is empty moves nothing and changes nothing.

The block derives two fill flags from the stored byte count.

- **Packet mode:** both thresholds are 6-bit values counted in four-byte groups. Almost empty compares the stored bytes against its threshold. Almost full compares the free bytes against its threshold.
- **Cell mode:** the data is made of fixed 53-byte cells. Almost empty compares the number of complete cells against the low two bits of its threshold. Almost full is held low.

A system-side poller reads the flags through a registered status output. The output answers only when the poll address equals the configured port address. An optional mode treats the all-ones port address as "disabled".

Top module: `rxf_poll_top`

## Requirements
- R1: Bytes leave the read port in the order they were written. `rd_data` shows the oldest stored byte whenever `rd_valid` is 1. The buffer holds up to 512 bytes.
- R2: While 512 bytes are stored, `wr_ready` is 0. A byte offered with `wr_valid`=1 is dropped and never appears on the read port. `wr_overflow` is 1 for exactly the one cycle after that edge.
- R3: While the buffer is empty, `rd_valid` is 0. Asserting `rd_ready` does not change the stored count or the order of later data.
- R4: In packet mode (`cell_mode`=0), `almost_empty` is 1 when the stored bytes are at most 4*`ae_level`. The flag is registered and follows the count one clock later.
- R5: In packet mode, `almost_full` is 1 when the free bytes (512 minus the stored bytes) are at most 4*`af_level`.
- R6: In cell mode (`cell_mode`=1), `almost_empty` is 1 when floor(stored/53) is at most `ae_level[1:0]`. Bits 5:2 of `ae_level` have no effect.
- R7: In cell mode, `almost_full` is 0 whatever the value of `af_level` and the fill level.
- R8: `poll_status` is registered and has the layout {bit1 = almost_full, bit0 = almost_empty}. One clock after `poll_addr` equals `port_id`, it shows the flags. When the two differ, it is 2'b00.
- R9: When `lvl2_mode`=1 and `port_id`=5'h1F, `poll_status` is always 2'b00.
- R10: A synchronous reset (`rst`=1) empties the buffer, sets `almost_empty` to 1, and clears `almost_full`, `wr_overflow` and `poll_status`.
- R11: Changing `cell_mode` or either level re-evaluates the flags on the next clock. It does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Space available for a byte |
| wr_overflow | output | 1 | One-cycle pulse when an offered byte was dropped |
| rd_ready | input | 1 | Reader takes the shown byte |
| rd_valid | output | 1 | A stored byte is shown |
| rd_data | output | 8 | Oldest stored byte |
| cell_mode | input | 1 | 1 = cell mode, 0 = packet mode |
| ae_level | input | 6 | Almost-empty threshold |
| af_level | input | 6 | Almost-full threshold |
| port_id | input | 5 | Port address of this buffer |
| lvl2_mode | input | 1 | When 1, port address 5'h1F disables polling |
| poll_addr | input | 5 | Address presented by the poller |
| poll_status | output | 2 | Registered polled flags {almost_full, almost_empty} |
| almost_empty | output | 1 | Registered almost-empty flag |
| almost_full | output | 1 | Registered almost-full flag |

## Verification
On every cycle, the assertions check several properties.

- A full buffer stays full unless a byte is read, and an empty buffer stays empty unless a byte is written.
- `almost_full` stays low in cell mode.
- A non-matching or disabled poll address yields zero status on the next cycle.
- Reset produces the documented flag state.

Only the bench scenarios can show the rest:

- The order of the data.
- That a dropped byte never appears on the read port.
- The exact threshold boundaries in each mode, including the ignored upper bits in cell mode.
- That a mode change leaves the stored bytes intact.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic full_near;
    logic empty_near;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_overflow,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push, pop, full, empty;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign push     = wr_valid && !full;
  assign pop      = rd_ready && !empty;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp          <= '0;
      rp          <= '0;
      count       <= '0;
      wr_overflow <= 1'b0;
    end else begin
      wr_overflow <= wr_valid && full;
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !(rd_ready && rd_valid)) |=> !wr_ready); // R2
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !wr_valid) |=> !rd_valid); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH      = 512,
  parameter int CELL_BYTES = 53,
  parameter int LW         = 6,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          cell_mode,
  input  logic [LW-1:0] ae_level,
  input  logic [LW-1:0] af_level,
  output rxf_pkg::rxf_flags_t flags
);
  logic [CW-1:0] free_b, ae_thr, af_thr, cells;
  logic pkt_ae, pkt_af, cell_ae;

  assign free_b  = CW'(DEPTH) - count;
  assign ae_thr  = CW'({ae_level, 2'b00});
  assign af_thr  = CW'({af_level, 2'b00});
  assign cells   = count / CW'(CELL_BYTES);
  assign pkt_ae  = (count <= ae_thr);
  assign pkt_af  = (free_b <= af_thr);
  assign cell_ae = (cells <= CW'(ae_level[1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.empty_near <= 1'b1;
      flags.full_near  <= 1'b0;
    end else if (cell_mode) begin
      flags.empty_near <= cell_ae;
      flags.full_near  <= 1'b0;
    end else begin
      flags.empty_near <= pkt_ae;
      flags.full_near  <= pkt_af;
    end
  end

  AST_CELL_NO_AF: assert property (@(posedge clk) disable iff (rst)
    cell_mode |=> !flags.full_near); // R7
endmodule

// File: rtl/rxf_poll.sv
module rxf_poll #(
  parameter int PAW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PAW-1:0] port_id,
  input  logic           lvl2_mode,
  input  logic [PAW-1:0] poll_addr,
  input  rxf_pkg::rxf_flags_t flags,
  output logic [1:0]     poll_status
);
  logic disabled, hit;

  assign disabled = lvl2_mode && (port_id == '1);
  assign hit      = (poll_addr == port_id) && !disabled;

  always_ff @(posedge clk) begin
    if (rst)      poll_status <= 2'b00;
    else if (hit) poll_status <= flags;
    else          poll_status <= 2'b00;
  end

  AST_POLL_MISS: assert property (@(posedge clk) disable iff (rst)
    (poll_addr != port_id) |=> (poll_status == 2'b00)); // R8
  AST_PORT_OFF: assert property (@(posedge clk) disable iff (rst)
    (lvl2_mode && port_id == '1) |=> (poll_status == 2'b00)); // R9
endmodule

// File: rtl/rxf_poll_top.sv
module rxf_poll_top #(
  parameter int DEPTH      = 512,
  parameter int DW         = 8,
  parameter int CELL_BYTES = 53,
  parameter int LW         = 6,
  parameter int PAW        = 5,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_valid,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_ready,
  output logic           wr_overflow,
  input  logic           rd_ready,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  input  logic           cell_mode,
  input  logic [LW-1:0]  ae_level,
  input  logic [LW-1:0]  af_level,
  input  logic [PAW-1:0] port_id,
  input  logic           lvl2_mode,
  input  logic [PAW-1:0] poll_addr,
  output logic [1:0]     poll_status,
  output logic           almost_empty,
  output logic           almost_full
);
  logic [CW-1:0] count;
  rxf_pkg::rxf_flags_t flags;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_overflow(wr_overflow), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .count(count));

  rxf_level #(.DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES), .LW(LW)) u_level (
    .clk(clk), .rst(rst), .count(count), .cell_mode(cell_mode),
    .ae_level(ae_level), .af_level(af_level), .flags(flags));

  rxf_poll #(.PAW(PAW)) u_poll (
    .clk(clk), .rst(rst), .port_id(port_id), .lvl2_mode(lvl2_mode),
    .poll_addr(poll_addr), .flags(flags), .poll_status(poll_status));

  assign almost_empty = flags.empty_near;
  assign almost_full  = flags.full_near;

  AST_RESET_FLAGS: assert property (@(posedge clk)
    rst |=> (almost_empty && !almost_full && !wr_overflow && poll_status == 2'b00)); // R10
endmodule

// File: tb/sim_rxf_poll_top.sv
module sim_rxf_poll_top;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, wr_ready, wr_overflow, rd_ready = 0, rd_valid;
  logic [7:0] wr_data = 0, rd_data;
  logic cell_mode = 0, lvl2_mode = 0;
  logic [5:0] ae_level = 0, af_level = 0;
  logic [4:0] port_id = 5'd5, poll_addr = 5'd5;
  logic [1:0] poll_status;
  logic almost_empty, almost_full;
  int checks = 0, errors = 0;
  int wseq = 0, rseq = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxf_poll_top u0 (.clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_overflow(wr_overflow), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .cell_mode(cell_mode),
    .ae_level(ae_level), .af_level(af_level), .port_id(port_id),
    .lvl2_mode(lvl2_mode), .poll_addr(poll_addr), .poll_status(poll_status),
    .almost_empty(almost_empty), .almost_full(almost_full));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 8'(wseq); wseq++;
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic pop(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      rd_ready = 1;
      if (!rd_valid || rd_data != 8'(rseq)) bad++;
      rseq++;
      @(negedge clk);
    end
    rd_ready = 0;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; repeat (2) @(negedge clk);
    rst = 0; wseq = 0; rseq = 0;
  endtask

  task automatic t_reset();
    cell_mode = 0; ae_level = 0; af_level = 0; port_id = 5; poll_addr = 5; lvl2_mode = 0;
    do_reset();
    chk(almost_empty && !almost_full, "R10 flags", {almost_full, almost_empty}, 1);
    chk(poll_status == 0 && !wr_overflow, "R10 poll/ovf", poll_status, 0);
    chk(!rd_valid && wr_ready, "R10 empty", {rd_valid, wr_ready}, 1);
  endtask

  task automatic t_order();
    push(10); settle();
    pop(10, "R1 order");
    chk(!rd_valid, "R1 drained", rd_valid, 0);
  endtask

  task automatic t_empty_read();
    rd_ready = 1; repeat (3) @(negedge clk);
    chk(!rd_valid, "R3 rd_valid while empty", rd_valid, 0);
    rd_ready = 0;
    push(1); settle();
    chk(rd_valid && rd_data == 8'(rseq), "R3 data after empty reads", rd_data, rseq);
    pop(1, "R3 single");
    chk(!rd_valid, "R3 count unchanged", rd_valid, 0);
  endtask

  task automatic t_packet_full();
    ae_level = 2; af_level = 3;
    push(8); settle();
    chk(almost_empty && !almost_full, "R4 at 8 bytes", almost_empty, 1);
    chk(poll_status == 2'b01, "R8 status ae", poll_status, 1);
    push(1); settle();
    chk(!almost_empty, "R4 at 9 bytes", almost_empty, 0);
    push(491); settle();
    chk(almost_full, "R5 free 12", almost_full, 1);
    chk(poll_status == 2'b10, "R8 status af", poll_status, 2);
    pop(1, "R1 head");
    settle();
    chk(!almost_full, "R5 free 13", almost_full, 0);
    push(13); settle();
    chk(!wr_ready, "R2 full ready", wr_ready, 0);
    wr_valid = 1; wr_data = 8'hEE;
    @(negedge clk);
    chk(wr_overflow, "R2 overflow pulse", wr_overflow, 1);
    wr_valid = 0;
    @(negedge clk);
    chk(!wr_overflow, "R2 pulse one cycle", wr_overflow, 0);
    pop(512, "R2 dropped byte absent");
    chk(!rd_valid, "R2 exactly 512 stored", rd_valid, 0);
  endtask

  task automatic t_cell();
    do_reset();
    cell_mode = 1; ae_level = 6'b111101; af_level = 6'd63;
    push(105); settle();
    chk(almost_empty, "R6 one cell", almost_empty, 1);
    push(1); settle();
    chk(!almost_empty, "R6 two cells, upper bits ignored", almost_empty, 0);
    push(194); settle();
    chk(!almost_full, "R7 af ignored", almost_full, 0);
    cell_mode = 0;
    @(negedge clk);
    chk(almost_full && !almost_empty, "R11 mode change next clock",
        {almost_full, almost_empty}, 2);
    pop(300, "R11 data undisturbed");
  endtask

  task automatic t_poll();
    do_reset();
    poll_addr = 3; settle();
    chk(poll_status == 0, "R8 mismatch", poll_status, 0);
    poll_addr = 5; @(negedge clk);
    chk(poll_status == 2'b01, "R8 match one clock", poll_status, 1);
    port_id = 5'h1F; poll_addr = 5'h1F; lvl2_mode = 1; settle();
    chk(poll_status == 0, "R9 disabled port", poll_status, 0);
    lvl2_mode = 0; settle();
    chk(poll_status == 2'b01, "R9 address 1F allowed without option", poll_status, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_empty_read();
    t_packet_full();
    t_cell();
    t_poll();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule